// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that software arms, feeds and stops through a small register port. A prescaler divides the system clock into a slow tick (one tick stands for 0.6 s in the field; the divider is a parameter so that a short tick can be used in simulation). A down-counter, loaded from a programmable start value, moves by one on every tick while it is allowed to run. Software feeds the dog by writing anything to the count register, which pulls the counter back to the start value.

Expiry takes two stages. When a tick finds the counter at zero for the first time, a sticky timeout flag is set, an optional interrupt request pulse is raised and the counter starts over from the start value. If the counter runs out again while that flag is still set, a second sticky flag is set and a one-cycle system reset request is raised, unless a no-reboot lock bit is set. In that case the request is withheld and a boot status flag is set in its place. All three flags are write-1-to-clear. Routing of the reset and interrupt requests is left to the surrounding chip.

Top module: `twostage_wdt`

## Requirements
- R1: After reset the counter is halted (control bit 11 reads 1, all other control bits 0), the start value and the count both read 4, every status bit reads 0, and both request outputs are low.
- R2: A write to the start-value register (address 1) takes data bits [9:0] when their value is 4 or more; a value from 0 to 3 is ignored and the old start value remains. Bits [15:10] are never stored and read as 0.
- R3: A write of any data to the count register (address 0) loads the count with the current start value; this write overrides a tick in the same cycle. A read of address 0 returns the count in bits [9:0].
- R4: Control register (address 4) bit 11 set halts the counter; when it is clear the count drops by one once per tick, one tick every TICK_DIV clock cycles.
- R5: A tick that finds the count at 0 while the first-timeout flag (address 2, bit 3) is clear sets that flag and reloads the count from the start value.
- R6: On such a first expiry, smi_req_o pulses high for one cycle if control bit 1 is set; it stays low when bit 1 is clear and at every second expiry.
- R7: A tick that finds the count at 0 while the first-timeout flag is set sets the second-timeout flag (address 3, bit 1), reloads the count, and pulses rst_req_o for one cycle.
- R8: When control bit 0 (no-reboot lock) is set, a second expiry leaves rst_req_o low and sets the boot status flag (address 3, bit 2) instead.
- R9: Each status flag is cleared by writing 1 to its bit position; writing 0 to it leaves it unchanged.
- R10: bus_rdata_o is 0 when bus_sel_i is low and for unmapped addresses 5 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register port select |
| bus_wr_i | input | 1 | Write strobe, qualified by bus_sel_i |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| smi_req_o | output | 1 | One-cycle interrupt request on first expiry |
| rst_req_o | output | 1 | One-cycle system reset request on second expiry |

## Verification
A wrong count or a wrong start value is visible on the read port in the very cycle after the clock edge that produced it, because the bench keeps the count register addressed whenever it is idle and compares the read data on every clock. A status flag stuck or lost shows up either as a missing or extra request pulse at the next expiry, or at once when the status register is read. A mistake in the prescaler phase shifts the first decrement by at least one cycle and is caught at the first tick after the counter is released.

// File: rtl/twostage_wdt_pkg.sv
`timescale 1ns/1ps
package twostage_wdt_pkg;

    // Register port address width and register offsets
    localparam int unsigned REG_ADDR_W = 3;
    localparam logic [REG_ADDR_W-1:0] ADR_COUNT = 3'd0;
    localparam logic [REG_ADDR_W-1:0] ADR_START = 3'd1;
    localparam logic [REG_ADDR_W-1:0] ADR_STS_A = 3'd2;
    localparam logic [REG_ADDR_W-1:0] ADR_STS_B = 3'd3;
    localparam logic [REG_ADDR_W-1:0] ADR_CTRL  = 3'd4;

    // Bit positions inside the registers
    localparam int unsigned HALT_POS     = 11;
    localparam int unsigned SMI_EN_POS   = 1;
    localparam int unsigned NO_RBT_POS   = 0;
    localparam int unsigned FIRST_TO_POS = 3;
    localparam int unsigned SECOND_POS   = 1;
    localparam int unsigned BOOT_POS     = 2;

    typedef struct packed {
        logic count;
        logic start;
        logic sts_a;
        logic sts_b;
        logic ctrl;
    } reg_wr_t;

    typedef struct packed {
        logic halt;
        logic smi_en;
        logic no_reboot;
    } ctrl_t;

endpackage

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
    parameter int unsigned DIV = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] div_d, div_q;

    generate
        if (DIV <= 1) begin : g_every_clock
            always_comb begin
                tick_o = 1'b1;
                div_d  = '0;
            end
            logic unused_div;
            assign unused_div = ^div_q;
        end else begin : g_divide
            always_comb begin
                tick_o = (div_q == LAST);
                div_d  = tick_o ? '0 : div_q + DIV_W'(1);
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end
endmodule

// File: rtl/wdt_bus.sv
`timescale 1ns/1ps
module wdt_bus
    import twostage_wdt_pkg::*;
#(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned DATA_W = 16
) (
    input  logic                  sel_i,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]      count_i,
    input  logic [CNT_W-1:0]      start_i,
    input  ctrl_t                 ctrl_i,
    input  logic                  first_to_i,
    input  logic                  second_to_i,
    input  logic                  boot_i,
    output reg_wr_t               wr_o,
    output logic [DATA_W-1:0]     rdata_o
);
    always_comb begin
        wr_o       = '0;
        if (sel_i && wr_i) begin
            unique case (addr_i)
                ADR_COUNT: wr_o.count = 1'b1;
                ADR_START: wr_o.start = 1'b1;
                ADR_STS_A: wr_o.sts_a = 1'b1;
                ADR_STS_B: wr_o.sts_b = 1'b1;
                ADR_CTRL:  wr_o.ctrl  = 1'b1;
                default:   wr_o       = '0;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i) begin
            unique case (addr_i)
                ADR_COUNT: rdata_o[CNT_W-1:0] = count_i;
                ADR_START: rdata_o[CNT_W-1:0] = start_i;
                ADR_STS_A: rdata_o[FIRST_TO_POS] = first_to_i;
                ADR_STS_B: begin
                    rdata_o[SECOND_POS] = second_to_i;
                    rdata_o[BOOT_POS]   = boot_i;
                end
                ADR_CTRL: begin
                    rdata_o[HALT_POS]   = ctrl_i.halt;
                    rdata_o[SMI_EN_POS] = ctrl_i.smi_en;
                    rdata_o[NO_RBT_POS] = ctrl_i.no_reboot;
                end
                default: rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_config.sv
`timescale 1ns/1ps
module wdt_config
    import twostage_wdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned MIN_INIT = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_start_i,
    input  logic              wr_ctrl_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  start_o,
    output ctrl_t             ctrl_o
);
    localparam logic [CNT_W-1:0] START_RST = CNT_W'(MIN_INIT);

    typedef struct packed {
        logic [CNT_W-1:0] start;
        ctrl_t            ctrl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [CNT_W-1:0] new_start;
    logic unused_wdata;

    assign new_start    = wdata_i[CNT_W-1:0];
    assign unused_wdata = ^wdata_i;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_start_i && (new_start >= START_RST)) begin
            cfg_d.start = new_start;
        end
        if (wr_ctrl_i) begin
            cfg_d.ctrl.halt      = wdata_i[HALT_POS];
            cfg_d.ctrl.smi_en    = wdata_i[SMI_EN_POS];
            cfg_d.ctrl.no_reboot = wdata_i[NO_RBT_POS];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.start          <= START_RST;
            cfg_q.ctrl.halt      <= 1'b1;
            cfg_q.ctrl.smi_en    <= 1'b0;
            cfg_q.ctrl.no_reboot <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign start_o = cfg_q.start;
    assign ctrl_o  = cfg_q.ctrl;
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
    import twostage_wdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned MIN_INIT = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  ctrl_t             ctrl_i,
    input  logic [CNT_W-1:0]  start_i,
    input  logic              wr_count_i,
    input  logic              wr_sts_a_i,
    input  logic              wr_sts_b_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              first_to_o,
    output logic              second_to_o,
    output logic              boot_o,
    output logic              smi_req_o,
    output logic              rst_req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             first_to;
        logic             second_to;
        logic             boot;
        logic             smi;
        logic             rst;
    } core_t;

    core_t st_d, st_q;
    logic  expire;
    logic  unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d     = st_q;
        st_d.smi = 1'b0;
        st_d.rst = 1'b0;
        expire   = 1'b0;

        // write-1-to-clear status; a set below overrides
        if (wr_sts_a_i && wdata_i[FIRST_TO_POS]) st_d.first_to  = 1'b0;
        if (wr_sts_b_i && wdata_i[SECOND_POS])   st_d.second_to = 1'b0;
        if (wr_sts_b_i && wdata_i[BOOT_POS])     st_d.boot      = 1'b0;

        if (wr_count_i) begin
            st_d.cnt = start_i;
        end else if (tick_i && !ctrl_i.halt) begin
            if (st_q.cnt == '0) begin
                expire   = 1'b1;
                st_d.cnt = start_i;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        if (expire) begin
            if (!st_q.first_to) begin
                st_d.first_to = 1'b1;
                st_d.smi      = ctrl_i.smi_en;
            end else begin
                st_d.second_to = 1'b1;
                if (ctrl_i.no_reboot) st_d.boot = 1'b1;
                else                  st_d.rst  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt       <= CNT_W'(MIN_INIT);
            st_q.first_to  <= 1'b0;
            st_q.second_to <= 1'b0;
            st_q.boot      <= 1'b0;
            st_q.smi       <= 1'b0;
            st_q.rst       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o     = st_q.cnt;
    assign first_to_o  = st_q.first_to;
    assign second_to_o = st_q.second_to;
    assign boot_o      = st_q.boot;
    assign smi_req_o   = st_q.smi;
    assign rst_req_o   = st_q.rst;
endmodule

// File: rtl/twostage_wdt.sv
`timescale 1ns/1ps
module twostage_wdt
    import twostage_wdt_pkg::*;
#(
    parameter int unsigned TICK_DIV = 8,
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned MIN_INIT = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bus_sel_i,
    input  logic                  bus_wr_i,
    input  logic [REG_ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    output logic                  smi_req_o,
    output logic                  rst_req_o
);
    logic             tick_w;
    reg_wr_t          wr_w;
    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] start_w;
    logic [CNT_W-1:0] count_w;
    logic             first_to_w, second_to_w, boot_w;
    logic             halt_w, no_reboot_w;

    assign halt_w      = ctrl_w.halt;
    assign no_reboot_w = ctrl_w.no_reboot;

    wdt_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick_w)
    );

    wdt_bus #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_bus (
        .sel_i       (bus_sel_i),
        .wr_i        (bus_wr_i),
        .addr_i      (bus_addr_i),
        .count_i     (count_w),
        .start_i     (start_w),
        .ctrl_i      (ctrl_w),
        .first_to_i  (first_to_w),
        .second_to_i (second_to_w),
        .boot_i      (boot_w),
        .wr_o        (wr_w),
        .rdata_o     (bus_rdata_o)
    );

    wdt_config #(.CNT_W(CNT_W), .DATA_W(DATA_W), .MIN_INIT(MIN_INIT)) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_start_i (wr_w.start),
        .wr_ctrl_i  (wr_w.ctrl),
        .wdata_i    (bus_wdata_i),
        .start_o    (start_w),
        .ctrl_o     (ctrl_w)
    );

    wdt_core #(.CNT_W(CNT_W), .DATA_W(DATA_W), .MIN_INIT(MIN_INIT)) u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_w),
        .ctrl_i      (ctrl_w),
        .start_i     (start_w),
        .wr_count_i  (wr_w.count),
        .wr_sts_a_i  (wr_w.sts_a),
        .wr_sts_b_i  (wr_w.sts_b),
        .wdata_i     (bus_wdata_i),
        .count_o     (count_w),
        .first_to_o  (first_to_w),
        .second_to_o (second_to_w),
        .boot_o      (boot_w),
        .smi_req_o   (smi_req_o),
        .rst_req_o   (rst_req_o)
    );
endmodule

// File: rtl/twostage_wdt_chk.sv
`timescale 1ns/1ps
module twostage_wdt_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             smi_req_o,
    input logic             rst_req_o,
    input logic [CNT_W-1:0] count_w,
    input logic [CNT_W-1:0] start_w,
    input logic             halt_w,
    input logic             no_reboot_w,
    input logic             first_to_w,
    input logic             second_to_w,
    input logic             wr_count_w
);
    // R6
    req_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(smi_req_o && rst_req_o));

    // R7
    rst_needs_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> second_to_w);

    // R8
    rst_not_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> !$past(no_reboot_w));

    // R4
    halt_freezes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_w && !wr_count_w) |=> $stable(count_w));

    // R6
    smi_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smi_req_o |-> first_to_w);

    // R5
    first_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(first_to_w) |-> (count_w == $past(start_w)));
endmodule

bind twostage_wdt twostage_wdt_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smi_req_o   (smi_req_o),
    .rst_req_o   (rst_req_o),
    .count_w     (count_w),
    .start_w     (start_w),
    .halt_w      (halt_w),
    .no_reboot_w (no_reboot_w),
    .first_to_w  (first_to_w),
    .second_to_w (second_to_w),
    .wr_count_w  (wr_w.count)
);

// File: tb/twostage_wdt_tb_top.sv
`timescale 1ns/1ps
module twostage_wdt_tb_top;
    localparam int DIV = 8;
    localparam int A_CNT = 0, A_START = 1, A_STA = 2, A_STB = 3, A_CTRL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        smi, rstq;

    int checks = 0, fails = 0, cyc = 0;
    int smi_seen = 0, rst_seen = 0;

    // behavioural reference state
    int m_div, m_cnt, m_start;
    bit m_halt, m_smien, m_norb, m_to1, m_to2, m_boot, m_smi, m_rst;

    always #2.5 clk = ~clk;

    twostage_wdt #(.TICK_DIV(DIV)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .smi_req_o(smi), .rst_req_o(rstq)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
            summary();
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_div = 0; m_cnt = 4; m_start = 4;
        m_halt = 1; m_smien = 0; m_norb = 0;
        m_to1 = 0; m_to2 = 0; m_boot = 0; m_smi = 0; m_rst = 0;
    endtask

    function automatic int model_read(bit s, int a);
        if (!s) return 0;
        case (a)
            A_CNT:   return m_cnt;
            A_START: return m_start;
            A_STA:   return m_to1 ? 8 : 0;
            A_STB:   return (m_to2 ? 2 : 0) + (m_boot ? 4 : 0);
            A_CTRL:  return (m_halt ? 2048 : 0) + (m_smien ? 2 : 0) + (m_norb ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    task automatic model_step(bit s, bit w, int a, int d);
        bit tick = (m_div == DIV - 1);
        bit we = s && w;
        bit expire = 0;
        int n_cnt = m_cnt;
        int n_start = m_start;
        bit n_to1 = m_to1, n_to2 = m_to2, n_boot = m_boot;
        bit n_halt = m_halt, n_smien = m_smien, n_norb = m_norb;
        bit n_smi = 0, n_rst = 0;
        if (we && a == A_STA && d[3]) n_to1 = 0;
        if (we && a == A_STB && d[1]) n_to2 = 0;
        if (we && a == A_STB && d[2]) n_boot = 0;
        if (we && a == A_START && (d % 1024) >= 4) n_start = d % 1024;
        if (we && a == A_CTRL) begin
            n_halt = d[11]; n_smien = d[1]; n_norb = d[0];
        end
        if (we && a == A_CNT) n_cnt = m_start;
        else if (tick && !m_halt) begin
            if (m_cnt == 0) begin expire = 1; n_cnt = m_start; end
            else n_cnt = m_cnt - 1;
        end
        if (expire) begin
            if (!m_to1) begin n_to1 = 1; n_smi = m_smien; end
            else begin
                n_to2 = 1;
                if (m_norb) n_boot = 1; else n_rst = 1;
            end
        end
        m_div = tick ? 0 : m_div + 1;
        m_cnt = n_cnt; m_start = n_start;
        m_to1 = n_to1; m_to2 = n_to2; m_boot = n_boot;
        m_halt = n_halt; m_smien = n_smien; m_norb = n_norb;
        m_smi = n_smi; m_rst = n_rst;
    endtask

    // one clock: drive at negedge, advance the model, compare at next negedge
    task automatic cycle(bit s, bit w, int a, int d);
        sel = s; wr = w; addr = 3'(a); wdata = 16'(d);
        model_step(s, w, a, d);
        @(negedge clk);
        check("R10 per-cycle rdata", int'(rdata), model_read(s, a));
        check("R6 per-cycle smi_req", int'(smi), int'(m_smi));
        check("R7 per-cycle rst_req", int'(rstq), int'(m_rst));
        if (smi) smi_seen++;
        if (rstq) rst_seen++;
    endtask

    task automatic wr_reg(int a, int d);
        cycle(1, 1, a, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(1, 0, A_CNT, 0);
    endtask

    task automatic rd(int a, output int v);
        cycle(1, 0, a, 0);
        v = int'(rdata);
    endtask

    initial begin
        int v, c0, smi_base, rst_base;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rdata idle", int'(rdata), 0);
        check("R1 smi_req low", int'(smi), 0);
        check("R1 rst_req low", int'(rstq), 0);
        rd(A_CNT, v);   check("R1 count", v, 4);
        rd(A_START, v); check("R1 start value", v, 4);
        rd(A_CTRL, v);  check("R1 control", v, 16'h0800);
        rd(A_STA, v);   check("R1 status A", v, 0);
        rd(A_STB, v);   check("R1 status B", v, 0);

        wr_reg(A_START, 3);
        rd(A_START, v); check("R2 illegal start ignored", v, 4);
        wr_reg(A_START, 16'hFC0A);
        rd(A_START, v); check("R2 start low bits only", v, 16'h000A);

        wr_reg(A_CNT, 16'h0055);
        rd(A_CNT, v); check("R3 reload to start", v, 10);
        idle(4 * DIV);
        rd(A_CNT, v); check("R4 halted count frozen", v, 10);

        smi_base = smi_seen; rst_base = rst_seen;
        wr_reg(A_CTRL, 16'h0002);
        idle(3 * DIV);
        rd(A_CNT, v); check("R4 count moved by ticks", int'(v >= 6 && v <= 7), 1);
        idle(12 * DIV);
        check("R6 one smi pulse", smi_seen - smi_base, 1);
        check("R5 no reset yet", rst_seen - rst_base, 0);
        rd(A_STA, v); check("R5 first flag", v, 16'h0008);
        idle(8 * DIV);
        check("R7 one reset pulse", rst_seen - rst_base, 1);
        check("R6 no smi at second expiry", smi_seen - smi_base, 1);
        rd(A_STB, v); check("R7 second flag", v, 16'h0002);

        wr_reg(A_STA, 16'hFFF7);
        rd(A_STA, v); check("R9 zero bit keeps flag", v, 16'h0008);
        wr_reg(A_STA, 16'h0008);
        rd(A_STA, v); check("R9 first flag cleared", v, 0);
        wr_reg(A_STB, 16'h0002);
        rd(A_STB, v); check("R9 second flag cleared", v, 0);

        wr_reg(A_CTRL, 16'h0800);
        rd(A_CNT, c0);
        idle(3 * DIV);
        rd(A_CNT, v); check("R4 halt stops count", v, c0);

        wr_reg(A_CNT, 0);
        smi_base = smi_seen; rst_base = rst_seen;
        wr_reg(A_CTRL, 16'h0001);
        idle(26 * DIV);
        check("R6 smi disabled", smi_seen - smi_base, 0);
        check("R8 reset withheld", rst_seen - rst_base, 0);
        rd(A_STB, v); check("R8 boot and second flags", v, 16'h0006);
        rd(A_STA, v); check("R5 first flag again", v, 16'h0008);
        wr_reg(A_CTRL, 16'h0800);
        wr_reg(A_STB, 16'h0006);
        rd(A_STB, v); check("R9 status B cleared", v, 0);

        cycle(0, 0, A_START, 0);
        check("R10 deselected reads zero", int'(rdata), 0);
        rd(7, v); check("R10 unmapped reads zero", v, 0);

        summary();
    end
endmodule